// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit is the per-processor acceptance core of a local interrupt controller. It holds three 256-bit vectors, one bit per interrupt vector number. The first records pending requests. The second records requests the processor has taken and not yet retired. The third records whether each request was level or edge triggered. The unit works out the processor priority from a programmable task priority and from the highest vector in service. It raises a single interrupt line towards the processor when a pending request should preempt that priority.

The processor takes interrupts through an acknowledge handshake. Each acknowledge returns either the best pending vector, which then moves into service, or the programmed spurious vector. It retires interrupts by writing the end-of-interrupt word. A word-wide register port exposes the task priority, the computed processor priority, the spurious/enable register and all three 256-bit vectors as 32-bit words. Priority comparisons for the interrupt line work on 16-vector classes, which are the upper nibble of a vector number. A higher number always wins.

Top module: `vec_prio_core`

## Requirements
- R1: After reset the request, in-service and trigger vectors are all zero, the task priority reads 0x00, the spurious/enable register reads 0x0FF (unit disabled), `irq_out` is 0 and `ack_done` is 0.
- R2: A cycle with `req_valid` high sets request bit `req_vector` and sets its trigger bit when `req_level` is 1 or clears it when 0. Bit v is readable at word index 0x20+v[7:5] (request) or 0x18+v[7:5] (trigger), at bit position v[4:0].
- R3: A write to word index 0x0F stores only bits 8:0. Bit 8 enables the unit and bits 7:0 are the spurious vector.
- R4: The processor priority (read-only, index 0x0A) equals the task priority (index 0x08, all 8 bits written) when the task class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that in-service class followed by four zero bits. An empty in-service vector counts as class 0.
- R5: `irq_out` is a register updated every cycle. It is 1 in the cycle after a state in which the unit is enabled, some request is pending, and either the processor priority is zero or the class of the highest pending vector is strictly greater than the processor priority's class.
- R6: An `ack_req` cycle is answered by `ack_done` high in the next cycle, with `ack_vector` valid. If the acknowledge is granted, the highest pending vector is returned, its request bit is cleared and its in-service bit is set.
- R7: An acknowledge returns the spurious vector and leaves the request and in-service vectors untouched in three cases: the unit is disabled, no request is pending, or the task priority is nonzero and the highest pending vector is less than or equal to the task priority (full 8-bit compare).
- R8: A write to word index 0x0B clears the highest set in-service bit and leaves the request vector alone. When nothing is in service it changes nothing.
- R9: Reads return in-service words at 0x10+w and the registers listed above. Every other index reads as zero, and writes to read-only or unlisted indices have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one vector per cycle |
| req_vector | input | 8 | Vector number of the request |
| req_level | input | 1 | Trigger mode of the request, 1 = level |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_done | output | 1 | Acknowledge answer valid, one cycle after `ack_req` |
| ack_vector | output | 8 | Vector returned by the acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The interrupt line is driven through three conditions in turn. A pending vector in the same class as the in-service vector must stay quiet, and a vector one class higher must fire; this separates a class compare from a full-vector compare. A task priority of 0x4E against pending vector 0x4F keeps the line low, yet the acknowledge still delivers 0x4F. Only this pair tells the nibble-based line rule apart from the 8-bit acknowledge rule. Repeated end-of-interrupt writes over two in-service vectors, plus one extra write with nothing in service, show highest-first retirement and the empty no-op. Vector 0xFF, a level request overwritten by an edge request on the same vector, and acknowledges made while disabled cover the bit-position edges, trigger-bit clearing and the enable gate.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  localparam int unsigned VEC_W   = 8;
  localparam int unsigned CLS_W   = 4;
  localparam int unsigned SVR_W   = 9;

  // word indices of the register port
  localparam logic [7:0] IDX_TPR = 8'h08;
  localparam logic [7:0] IDX_PPR = 8'h0A;
  localparam logic [7:0] IDX_EOI = 8'h0B;
  localparam logic [7:0] IDX_SVR = 8'h0F;
  localparam logic [4:0] GRP_ISR = 5'b00010;  // 0x10..0x17
  localparam logic [4:0] GRP_TMR = 5'b00011;  // 0x18..0x1F
  localparam logic [4:0] GRP_IRR = 5'b00100;  // 0x20..0x27

  // processor priority from task priority and top in-service vector
  function automatic logic [VEC_W-1:0] calc_ppr(input logic [VEC_W-1:0] tpr,
                                                input logic             isr_any,
                                                input logic [VEC_W-1:0] isr_top);
    logic [CLS_W-1:0] icls;
    icls = isr_any ? isr_top[VEC_W-1 -: CLS_W] : '0;
    if (tpr[VEC_W-1 -: CLS_W] >= icls) return tpr;
    return {icls, {(VEC_W-CLS_W){1'b0}}};
  endfunction

  // should the line to the processor be raised
  function automatic logic line_wanted(input logic             en,
                                       input logic             irr_any,
                                       input logic [VEC_W-1:0] irr_top,
                                       input logic [VEC_W-1:0] ppr);
    if (!en || !irr_any) return 1'b0;
    if (ppr == '0) return 1'b1;
    return irr_top[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W];
  endfunction

  // acknowledge answered with the spurious vector
  function automatic logic ack_refused(input logic             en,
                                       input logic             irr_any,
                                       input logic [VEC_W-1:0] irr_top,
                                       input logic [VEC_W-1:0] tpr);
    if (!en || !irr_any) return 1'b1;
    return (tpr != '0) && (irr_top <= tpr);
  endfunction

endpackage

// File: rtl/vpc_hi_find.sv
module vpc_hi_find #(
  parameter int unsigned N  = 256,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vpc_vecbank.sv
module vpc_vecbank #(
  parameter int unsigned NVEC = 256,
  localparam int unsigned IW  = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IW-1:0]   set_vec,
  input  logic            set_level,
  input  logic            take_en,
  input  logic [IW-1:0]   take_vec,
  input  logic            retire_en,
  input  logic [IW-1:0]   retire_vec,
  output logic [NVEC-1:0] irr_o,
  output logic [NVEC-1:0] isr_o,
  output logic [NVEC-1:0] tmr_o
);
  logic [NVEC-1:0] irr_nx, isr_nx, tmr_nx;

  for (genvar g = 0; g < NVEC; g++) begin : g_bit
    logic hit_set, hit_take, hit_ret;
    assign hit_set  = set_en    && (set_vec    == IW'(g));
    assign hit_take = take_en   && (take_vec   == IW'(g));
    assign hit_ret  = retire_en && (retire_vec == IW'(g));
    // a new request wins over the acknowledge that clears the same bit
    assign irr_nx[g] = (irr_o[g] && !hit_take) || hit_set;
    assign isr_nx[g] = (isr_o[g] || hit_take) && !hit_ret;
    assign tmr_nx[g] = hit_set ? set_level : tmr_o[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_o <= '0;
      isr_o <= '0;
      tmr_o <= '0;
    end else begin
      irr_o <= irr_nx;
      isr_o <= isr_nx;
      tmr_o <= tmr_nx;
    end
  end
endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core
  import vpc_pkg::*;
#(
  parameter int unsigned NVEC   = 256,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IW    = $clog2(NVEC),
  localparam int unsigned NWORD = NVEC / WORD_W,
  localparam int unsigned WSEL  = $clog2(NWORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IW-1:0]     req_vector,
  input  logic              req_level,
  input  logic              ack_req,
  output logic              ack_done,
  output logic [IW-1:0]     ack_vector,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
  logic [IW-1:0]    tpr_q;
  logic [SVR_W-1:0] svr_q;
  logic             irr_any, isr_any;
  logic [IW-1:0]    irr_top, isr_top;
  logic [IW-1:0]    ppr;

  // named internal events
  logic             unit_en;
  logic             ack_spur;
  logic             ack_take;
  logic             eoi_fire;
  logic             irq_nx;

  vpc_hi_find #(.N(NVEC)) u_irr_find (.bits_i(irr_q), .any_o(irr_any), .idx_o(irr_top));
  vpc_hi_find #(.N(NVEC)) u_isr_find (.bits_i(isr_q), .any_o(isr_any), .idx_o(isr_top));

  assign unit_en  = svr_q[SVR_W-1];
  assign ppr      = calc_ppr(tpr_q, isr_any, isr_top);
  assign ack_spur = ack_refused(unit_en, irr_any, irr_top, tpr_q);
  assign ack_take = ack_req && !ack_spur;
  assign eoi_fire = reg_wr && (reg_addr == IDX_EOI);
  assign irq_nx   = line_wanted(unit_en, irr_any, irr_top, ppr);

  vpc_vecbank #(.NVEC(NVEC)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (req_valid),
    .set_vec    (req_vector),
    .set_level  (req_level),
    .take_en    (ack_take),
    .take_vec   (irr_top),
    .retire_en  (eoi_fire && isr_any),
    .retire_vec (isr_top),
    .irr_o      (irr_q),
    .isr_o      (isr_q),
    .tmr_o      (tmr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q      <= '0;
      svr_q      <= {1'b0, {(SVR_W-1){1'b1}}};
      irq_out    <= 1'b0;
      ack_done   <= 1'b0;
      ack_vector <= '0;
    end else begin
      if (reg_wr && reg_addr == IDX_TPR) tpr_q <= reg_wdata[IW-1:0];
      if (reg_wr && reg_addr == IDX_SVR) svr_q <= reg_wdata[SVR_W-1:0];
      irq_out  <= irq_nx;
      ack_done <= ack_req;
      if (ack_req) ack_vector <= ack_spur ? svr_q[IW-1:0] : irr_top;
    end
  end

  // register read port
  logic [WSEL-1:0] rd_word;
  assign rd_word = reg_addr[WSEL-1:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IDX_TPR: reg_rdata = WORD_W'(tpr_q);
      IDX_PPR: reg_rdata = WORD_W'(ppr);
      IDX_SVR: reg_rdata = WORD_W'(svr_q);
      default: begin
        if (reg_addr[ADDR_W-1:WSEL] == GRP_ISR) reg_rdata = isr_q[rd_word*WORD_W +: WORD_W];
        if (reg_addr[ADDR_W-1:WSEL] == GRP_TMR) reg_rdata = tmr_q[rd_word*WORD_W +: WORD_W];
        if (reg_addr[ADDR_W-1:WSEL] == GRP_IRR) reg_rdata = irr_q[rd_word*WORD_W +: WORD_W];
      end
    endcase
  end

  // ---------------- assertions ----------------
  a_r2_req_lands: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> irr_q[$past(req_vector)] && (tmr_q[$past(req_vector)] == $past(req_level)));

  a_r4_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);

  a_r5_line_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(unit_en) && $past(irr_any));

  a_r6_ack_answered: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_done);

  a_r6_take_to_service: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> isr_q[$past(irr_top)]);

  a_r7_spurious_keeps_irr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && ack_spur && !req_valid) |=> $stable(irr_q));

  a_r8_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && isr_any && !ack_take) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

  a_r8_eoi_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !isr_any && !ack_take) |=> $stable(isr_q));

endmodule

// File: tb/test_vec_prio_core.sv
module test_vec_prio_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic        ack_req = 1'b0;
  logic        ack_done;
  logic [7:0]  ack_vector;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  vec_prio_core i_vec_prio_core (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
    .ack_req(ack_req), .ack_done(ack_done), .ack_vector(ack_vector),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl);
    @(negedge clk); req_valid = 1'b1; req_vector = v; req_level = lvl;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] idx, input logic [31:0] exp);
    reg_addr = idx;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic chk_ack(input string req, input logic [7:0] exp);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
    check({req, " ack_done"}, 32'(ack_done), 32'd1);
    check(req, 32'(ack_vector), 32'(exp));
  endtask

  // line is registered one cycle after the state it reflects
  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk);
    check(req, 32'(irq_out), 32'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 irq", 32'(irq_out), 32'd0);
    check("R1 ack_done", 32'(ack_done), 32'd0);
    chk_rd("R1 svr", 8'h0F, 32'h0FF);
    chk_rd("R1 tpr", 8'h08, 32'h0);
    chk_rd("R1 ppr", 8'h0A, 32'h0);
    for (int w = 0; w < 8; w++) begin
      chk_rd("R1 irr", 8'(8'h20 + w), 32'h0);
      chk_rd("R1 isr", 8'(8'h10 + w), 32'h0);
      chk_rd("R1 tmr", 8'(8'h18 + w), 32'h0);
    end
  endtask

  task automatic t_gate_and_enable;
    do_req(8'h45, 1'b0);
    chk_irq("R5 disabled unit stays quiet", 1'b0);
    chk_rd("R2 irr word2", 8'h22, 32'h0000_0020);
    do_wr(8'h0F, 32'hFFFF_F1A5);
    chk_rd("R3 svr keeps 8:0", 8'h0F, 32'h0000_01A5);
    chk_irq("R5 enabled fires", 1'b1);
  endtask

  task automatic t_first_ack;
    chk_ack("R6 deliver 0x45", 8'h45);
    chk_rd("R6 isr word2", 8'h12, 32'h0000_0020);
    chk_rd("R6 irr cleared", 8'h22, 32'h0);
    chk_rd("R4 ppr from isr", 8'h0A, 32'h40);
    chk_irq("R5 nothing pending", 1'b0);
  endtask

  task automatic t_class_compare;
    do_req(8'h4F, 1'b0);
    chk_irq("R5 same class blocked", 1'b0);
    do_req(8'h61, 1'b0);
    chk_irq("R5 higher class fires", 1'b1);
    chk_ack("R6 highest first", 8'h61);
    chk_rd("R4 ppr 0x60", 8'h0A, 32'h60);
    chk_irq("R5 blocked after ack", 1'b0);
  endtask

  task automatic t_tpr_spurious;
    do_wr(8'h08, 32'h70);
    chk_rd("R9 tpr read", 8'h08, 32'h70);
    chk_rd("R4 ppr from tpr", 8'h0A, 32'h70);
    chk_ack("R7 masked gives spurious", 8'hA5);
    chk_rd("R7 irr unchanged", 8'h22, 32'h0000_8000);
    chk_rd("R7 isr unchanged", 8'h13, 32'h0000_0002);
  endtask

  task automatic t_eoi;
    do_wr(8'h0B, 32'h0);
    chk_rd("R8 top isr cleared", 8'h13, 32'h0);
    chk_rd("R8 lower isr kept", 8'h12, 32'h0000_0020);
    do_wr(8'h0B, 32'h0);
    chk_rd("R8 second eoi", 8'h12, 32'h0);
    do_wr(8'h0B, 32'h0);
    chk_rd("R8 empty eoi word2", 8'h12, 32'h0);
    chk_rd("R8 empty eoi word3", 8'h13, 32'h0);
    chk_rd("R8 irr untouched", 8'h22, 32'h0000_8000);
  endtask

  task automatic t_nibble_vs_full;
    do_wr(8'h08, 32'h4E);
    chk_irq("R5 class not above tpr", 1'b0);
    chk_ack("R7 full compare delivers 0x4F", 8'h4F);
    do_wr(8'h08, 32'h35);
    chk_rd("R4 isr class wins", 8'h0A, 32'h40);
  endtask

  task automatic t_trigger;
    do_req(8'h50, 1'b1);
    chk_rd("R2 tmr level set", 8'h1A, 32'h0001_0000);
    chk_irq("R5 class 5 above 4", 1'b1);
    do_req(8'h50, 1'b0);
    chk_rd("R2 tmr edge clears", 8'h1A, 32'h0);
    chk_rd("R2 irr stays set", 8'h22, 32'h0001_0000);
  endtask

  task automatic t_top_vector;
    do_req(8'hFF, 1'b0);
    chk_rd("R2 vector 0xFF", 8'h27, 32'h8000_0000);
    chk_ack("R6 deliver 0xFF", 8'hFF);
    chk_rd("R6 isr 0xFF", 8'h17, 32'h8000_0000);
  endtask

  task automatic t_disable_and_unmapped;
    do_wr(8'h0F, 32'h0000_00A5);
    chk_irq("R5 disable drops line", 1'b0);
    chk_ack("R7 disabled gives spurious", 8'hA5);
    chk_rd("R7 irr kept while disabled", 8'h22, 32'h0001_0000);
    do_wr(8'h30, 32'hFFFF_FFFF);
    chk_rd("R9 unmapped reads zero", 8'h30, 32'h0);
    do_wr(8'h0A, 32'hFFFF_FFFF);
    chk_rd("R9 ppr read-only", 8'h0A, 32'hF0);
    do_wr(8'h22, 32'h0);
    chk_rd("R9 irr not writable", 8'h22, 32'h0001_0000);
  endtask

  task automatic t_empty_ack;
    do_wr(8'h0F, 32'h0000_01A5);
    do_wr(8'h08, 32'h00);
    chk_ack("R6 deliver 0x50", 8'h50);
    chk_ack("R7 empty irr gives spurious", 8'hA5);
  endtask

  task automatic t_midrun_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_rd("R1 isr cleared", 8'h17, 32'h0);
    chk_rd("R1 isr2 cleared", 8'h12, 32'h0);
    chk_rd("R1 svr back", 8'h0F, 32'h0FF);
    check("R1 irq after reset", 32'(irq_out), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate_and_enable();
    t_first_ack();
    t_class_compare();
    t_tpr_spurious();
    t_eoi();
    t_nibble_vs_full();
    t_trigger();
    t_top_vector();
    t_disable_and_unmapped();
    t_empty_ack();
    t_midrun_reset();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule